// File: doc/BRIEF.md
# CAN Error-Confinement Interrupt Flag Unit

This block follows the transmit and receive error counters of a CAN controller and turns the notable moments of those counters, together with a handful of mailbox and bus events, into sticky interrupt flags. The protocol engine feeds it step strobes for both counters, a strobe for every run of 11 recessive bits, per-mailbox completion pulses with the matching pending levels, an overload-sent pulse, a reset/halt-done pulse, the standby level and the raw receive pin. Frame decoding, bit timing and mailbox storage live elsewhere.

Every source owns one flag bit. A flag is set by its event and stays set until software writes 1 to that bit. All flags share one interrupt line, because every source uses the same vector and software must read the flags to tell them apart. A per-source mask can silence every source except reset/halt. A per-mailbox mask decides whether a mailbox may raise the receive flags at all.

Top module: `canerr_irq_top`

## Requirements
- R1: After reset all flags are 0, both counters read 0, `bus_off_o` is 0 and `irq_o` is 0.
- R2: On an edge with `tec_inc_i` high the transmit counter adds `tec_amt_i` and stops at 256. With only `tec_dec_i` high it subtracts 1 and stops at 0. The increment wins when both are high. The receive counter follows the same rules with its own inputs and stops at 255.
- R3: Flag bit 3 (transmit warning) sets when the transmit counter moves onto 96 from any other value, upward or downward. Flag bit 4 (receive warning) does the same for the receive counter.
- R4: Flag bit 5 (error passive) sets when either counter moves onto 128 from any other value, in either direction.
- R5: When the transmit counter reaches 256, flag bit 6 (bus off) sets and `bus_off_o` rises on that same edge. From the next edge both counters read 0, and count strobes change nothing while `bus_off_o` is high.
- R6: While in bus-off, the 128th `recseq_i` strobe clears `bus_off_o` and sets flag bit 6 again. Fewer strobes leave the block in bus-off. Strobes outside bus-off have no effect.
- R7: Flag bit 10 (wakeup) sets on a 1-to-0 transition of `rx_pin_i` while `standby_i` is high. The same transition with `standby_i` low is ignored.
- R8: Flag bit 9 (overrun) sets when a data or remote completion arrives for a mailbox whose `mb_mask_i` bit is 0 while that mailbox's `rx_pend_i` or `rmt_pend_i` bit is 1.
- R9: A data completion (`rx_done_i`) sets flag bit 1 and a remote completion (`rmt_done_i`) sets flag bit 2, but only when the mailbox's `mb_mask_i` bit is 0.
- R10: Flag bit 8 (mailbox empty) sets when any `tx_pend_i` bit goes from 1 to 0. A rise of a pending bit sets nothing.
- R11: `ovld_sent_i` sets flag bit 7 and `rsthlt_done_i` sets flag bit 0.
- R12: Writing 1 to a bit of `flag_clr_i` clears only that flag. A flag whose event occurs in the same cycle as its clear stays set.
- R13: `irq_o` is the OR over all flags with `src_mask_i` bit 1 (masked) removed. `src_mask_i` bit 0 has no effect, so a set flag 0 always drives `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tec_inc_i | input | 1 | Transmit counter increment strobe |
| tec_dec_i | input | 1 | Transmit counter decrement strobe |
| tec_amt_i | input | AMT_W | Transmit increment amount |
| rec_inc_i | input | 1 | Receive counter increment strobe |
| rec_dec_i | input | 1 | Receive counter decrement strobe |
| rec_amt_i | input | AMT_W | Receive increment amount |
| recseq_i | input | 1 | One run of 11 recessive bits seen |
| standby_i | input | 1 | Controller in standby |
| rx_pin_i | input | 1 | Raw receive pin |
| rx_done_i | input | NMB | Data frame stored, per mailbox |
| rmt_done_i | input | NMB | Remote frame stored, per mailbox |
| rx_pend_i | input | NMB | Data-received pending level, per mailbox |
| rmt_pend_i | input | NMB | Remote-received pending level, per mailbox |
| tx_pend_i | input | NMB | Transmit pending level, per mailbox |
| mb_mask_i | input | NMB | Mailbox interrupt mask, 1 = masked |
| ovld_sent_i | input | 1 | Overload frame sent |
| rsthlt_done_i | input | 1 | Reset or halt request completed |
| src_mask_i | input | 11 | Per-flag interrupt mask, 1 = masked |
| flag_clr_i | input | 11 | Write-1-to-clear strobes |
| flags_o | output | 11 | Sticky flags |
| irq_o | output | 1 | Shared interrupt line |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| bus_off_o | output | 1 | Bus-off state |

## Verification
The assertions check, on every cycle, that counters stay inside their ceilings and land on 96 or 128 whenever a threshold event is raised. They also check that flags only fall under a matching clear, that bus-off entry and exit follow their events, and that a pending reset/halt flag always drives the interrupt. Other behaviours only show up in the bench's scenarios: the exact crossing values on the way up and on the way down, saturation, the 128-run recovery count, gating by mailbox mask and pending bit, wakeup only in standby, and the interrupt under every mask value.

// File: rtl/canerr_pkg.sv
package canerr_pkg;

    localparam int NFLAG     = 11;
    localparam int F_RSTHLT  = 0;
    localparam int F_DATARX  = 1;
    localparam int F_RMTRX   = 2;
    localparam int F_TXWARN  = 3;
    localparam int F_RXWARN  = 4;
    localparam int F_PASSIVE = 5;
    localparam int F_BUSOFF  = 6;
    localparam int F_OVLD    = 7;
    localparam int F_EMPTY   = 8;
    localparam int F_OVRUN   = 9;
    localparam int F_WAKE    = 10;

    typedef logic [NFLAG-1:0] flag_vec_t;

endpackage

// File: rtl/errcnt_track.sv
module errcnt_track #(
    parameter int W       = 9,
    parameter int SAT     = 256,
    parameter int WARN    = 96,
    parameter int PASSIVE = 128,
    parameter int AMT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             clr_i,
    output logic [W-1:0]     cnt_o,
    output logic             warn_evt_o,
    output logic             pass_evt_o,
    output logic             full_evt_o
);

    localparam logic [W-1:0] SAT_V  = W'(SAT);
    localparam logic [W-1:0] WARN_V = W'(WARN);
    localparam logic [W-1:0] PASS_V = W'(PASSIVE);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t     st_d, st_q;
    logic [W:0]  sum_d;
    logic        moved_d;

    always_comb begin
        st_d  = st_q;
        sum_d = {1'b0, st_q.cnt} + (W+1)'(amt_i);
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt = (sum_d > {1'b0, SAT_V}) ? SAT_V : sum_d[W-1:0];
        end else if (dec_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        moved_d = (st_d.cnt != st_q.cnt);
    end

    assign warn_evt_o = moved_d && (st_d.cnt == WARN_V);
    assign pass_evt_o = moved_d && (st_d.cnt == PASS_V);
    assign full_evt_o = moved_d && (st_d.cnt == SAT_V);
    assign cnt_o      = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: counter never leaves its range
    a_r2_cnt_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= SAT_V);
    // R3: a warning event leaves the counter on the warning value
    a_r3_warn_lands: assert property (@(posedge clk) disable iff (!rst_n)
        warn_evt_o |=> cnt_o == WARN_V);
    // R4: a passive event leaves the counter on the passive value
    a_r4_pass_lands: assert property (@(posedge clk) disable iff (!rst_n)
        pass_evt_o |=> cnt_o == PASS_V);
    // R2: at the ceiling an increment keeps the value
    a_r2_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == SAT_V && inc_i && !clr_i) |=> cnt_o == SAT_V);

endmodule

// File: rtl/busoff_ctrl.sv
module busoff_ctrl #(
    parameter int SEQ_LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tec_full_i,
    input  logic seq_i,
    output logic bus_off_o,
    output logic enter_evt_o,
    output logic leave_evt_o
);

    localparam int SW = $clog2(SEQ_LIMIT + 1);
    localparam logic [SW-1:0] SEQ_LAST = SW'(SEQ_LIMIT - 1);

    typedef struct packed {
        logic          bo;
        logic [SW-1:0] seq;
    } bo_st_t;

    bo_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        enter_evt_o = 1'b0;
        leave_evt_o = 1'b0;
        if (!st_q.bo) begin
            if (tec_full_i) begin
                st_d.bo     = 1'b1;
                st_d.seq    = '0;
                enter_evt_o = 1'b1;
            end
        end else if (seq_i) begin
            if (st_q.seq == SEQ_LAST) begin
                st_d.bo     = 1'b0;
                st_d.seq    = '0;
                leave_evt_o = 1'b1;
            end else begin
                st_d.seq = st_q.seq + 1'b1;
            end
        end
    end

    assign bus_off_o = st_q.bo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: entering bus-off raises the state on the next edge
    a_r5_enter_state: assert property (@(posedge clk) disable iff (!rst_n)
        enter_evt_o |=> bus_off_o);
    // R6: leaving bus-off drops the state on the next edge
    a_r6_leave_state: assert property (@(posedge clk) disable iff (!rst_n)
        leave_evt_o |=> !bus_off_o);
    // R6: the run counter stays below the limit
    a_r6_seq_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seq <= SEQ_LAST);
    // R6: strobes outside bus-off do not move the run counter
    a_r6_seq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_off_o |-> st_q.seq == '0);

endmodule

// File: rtl/mb_events.sv
module mb_events #(
    parameter int NMB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NMB-1:0] rx_done_i,
    input  logic [NMB-1:0] rmt_done_i,
    input  logic [NMB-1:0] rx_pend_i,
    input  logic [NMB-1:0] rmt_pend_i,
    input  logic [NMB-1:0] tx_pend_i,
    input  logic [NMB-1:0] mb_mask_i,
    output logic           datarx_evt_o,
    output logic           rmtrx_evt_o,
    output logic           ovrun_evt_o,
    output logic           empty_evt_o
);

    typedef struct packed {
        logic [NMB-1:0] tx_prev;
    } mb_st_t;

    mb_st_t         st_d, st_q;
    logic [NMB-1:0] dat_v, rmt_v, ovr_v, fall_v;

    for (genvar i = 0; i < NMB; i++) begin : g_mb
        assign dat_v[i]  = rx_done_i[i]  & ~mb_mask_i[i];
        assign rmt_v[i]  = rmt_done_i[i] & ~mb_mask_i[i];
        assign ovr_v[i]  = (rx_done_i[i] | rmt_done_i[i]) & ~mb_mask_i[i]
                         & (rx_pend_i[i] | rmt_pend_i[i]);
        assign fall_v[i] = st_q.tx_prev[i] & ~tx_pend_i[i];
    end

    always_comb begin
        st_d         = st_q;
        st_d.tx_prev = tx_pend_i;
    end

    assign datarx_evt_o = |dat_v;
    assign rmtrx_evt_o  = |rmt_v;
    assign ovrun_evt_o  = |ovr_v;
    assign empty_evt_o  = |fall_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: fully masked mailboxes raise no receive event
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mb_mask_i) |-> !(datarx_evt_o || rmtrx_evt_o || ovrun_evt_o));
    // R10: no empty event while every pending bit was low last cycle
    a_r10_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        empty_evt_o |-> $past(tx_pend_i) != '0);

endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import canerr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_i,
    input  flag_vec_t clr_i,
    input  flag_vec_t src_mask_i,
    output flag_vec_t flags_o,
    output logic      irq_o
);

    typedef struct packed {
        flag_vec_t flags;
    } fb_st_t;

    fb_st_t    st_d, st_q;
    flag_vec_t mask_eff;

    always_comb begin
        st_d           = st_q;
        st_d.flags     = (st_q.flags & ~clr_i) | set_i;
        mask_eff       = src_mask_i;
        mask_eff[F_RSTHLT] = 1'b0;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |(st_q.flags & ~mask_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12: a flag falls only under its own clear bit
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags_o) & ~$past(clr_i) & ~flags_o) == '0));
    // R12: an event wins over a same-cycle clear
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> (($past(set_i) & ~flags_o) == '0));
    // R13: the reset/halt flag cannot be masked
    a_r13_rh_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[F_RSTHLT] |-> irq_o);

endmodule

// File: rtl/canerr_irq_top.sv
module canerr_irq_top
    import canerr_pkg::*;
#(
    parameter int NMB         = 4,
    parameter int AMT_W       = 4,
    parameter int SEQ_LIMIT   = 128,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tec_inc_i,
    input  logic             tec_dec_i,
    input  logic [AMT_W-1:0] tec_amt_i,
    input  logic             rec_inc_i,
    input  logic             rec_dec_i,
    input  logic [AMT_W-1:0] rec_amt_i,
    input  logic             recseq_i,
    input  logic             standby_i,
    input  logic             rx_pin_i,
    input  logic [NMB-1:0]   rx_done_i,
    input  logic [NMB-1:0]   rmt_done_i,
    input  logic [NMB-1:0]   rx_pend_i,
    input  logic [NMB-1:0]   rmt_pend_i,
    input  logic [NMB-1:0]   tx_pend_i,
    input  logic [NMB-1:0]   mb_mask_i,
    input  logic             ovld_sent_i,
    input  logic             rsthlt_done_i,
    input  logic [10:0]      src_mask_i,
    input  logic [10:0]      flag_clr_i,
    output logic [10:0]      flags_o,
    output logic             irq_o,
    output logic [8:0]       tec_o,
    output logic [7:0]       rec_o,
    output logic             bus_off_o
);

    localparam int TEC_W   = 9;
    localparam int REC_W   = 8;
    localparam int TEC_SAT = 1 << (TEC_W - 1);
    localparam int REC_SAT = (1 << REC_W) - 1;

    typedef struct packed {
        logic rx_prev;
    } top_st_t;

    top_st_t   st_d, st_q;
    logic      wake_evt;
    logic      tec_warn, tec_pass, tec_full;
    logic      rec_warn, rec_pass, rec_full;
    logic      bo_enter, bo_leave;
    logic      dat_evt, rmt_evt, ovr_evt, emp_evt;
    flag_vec_t set_v;

    always_comb begin
        st_d         = st_q;
        st_d.rx_prev = rx_pin_i;
        wake_evt     = standby_i & st_q.rx_prev & ~rx_pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rx_prev: 1'b1};
        else        st_q <= st_d;
    end

    errcnt_track #(
        .W(TEC_W), .SAT(TEC_SAT), .WARN(WARN_LVL), .PASSIVE(PASSIVE_LVL), .AMT_W(AMT_W)
    ) u_tec (
        .clk(clk), .rst_n(rst_n),
        .inc_i(tec_inc_i), .dec_i(tec_dec_i), .amt_i(tec_amt_i), .clr_i(bus_off_o),
        .cnt_o(tec_o), .warn_evt_o(tec_warn), .pass_evt_o(tec_pass), .full_evt_o(tec_full)
    );

    errcnt_track #(
        .W(REC_W), .SAT(REC_SAT), .WARN(WARN_LVL), .PASSIVE(PASSIVE_LVL), .AMT_W(AMT_W)
    ) u_rec (
        .clk(clk), .rst_n(rst_n),
        .inc_i(rec_inc_i), .dec_i(rec_dec_i), .amt_i(rec_amt_i), .clr_i(bus_off_o),
        .cnt_o(rec_o), .warn_evt_o(rec_warn), .pass_evt_o(rec_pass), .full_evt_o(rec_full)
    );

    busoff_ctrl #(.SEQ_LIMIT(SEQ_LIMIT)) u_bo (
        .clk(clk), .rst_n(rst_n),
        .tec_full_i(tec_full), .seq_i(recseq_i),
        .bus_off_o(bus_off_o), .enter_evt_o(bo_enter), .leave_evt_o(bo_leave)
    );

    mb_events #(.NMB(NMB)) u_mb (
        .clk(clk), .rst_n(rst_n),
        .rx_done_i(rx_done_i), .rmt_done_i(rmt_done_i),
        .rx_pend_i(rx_pend_i), .rmt_pend_i(rmt_pend_i),
        .tx_pend_i(tx_pend_i), .mb_mask_i(mb_mask_i),
        .datarx_evt_o(dat_evt), .rmtrx_evt_o(rmt_evt),
        .ovrun_evt_o(ovr_evt), .empty_evt_o(emp_evt)
    );

    always_comb begin
        set_v            = '0;
        set_v[F_RSTHLT]  = rsthlt_done_i;
        set_v[F_DATARX]  = dat_evt;
        set_v[F_RMTRX]   = rmt_evt;
        set_v[F_TXWARN]  = tec_warn;
        set_v[F_RXWARN]  = rec_warn;
        set_v[F_PASSIVE] = tec_pass | rec_pass;
        set_v[F_BUSOFF]  = bo_enter | bo_leave;
        set_v[F_OVLD]    = ovld_sent_i;
        set_v[F_EMPTY]   = emp_evt;
        set_v[F_OVRUN]   = ovr_evt;
        set_v[F_WAKE]    = wake_evt;
    end

    flag_bank u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_i(set_v), .clr_i(flag_clr_i), .src_mask_i(src_mask_i),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    // R2: the receive counter never reports a full event above its ceiling
    a_r2_rec_full_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        rec_full |=> rec_o == 8'(REC_SAT));
    // R5: counters read zero one edge into bus-off
    a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off_o && $past(bus_off_o)) |-> (tec_o == '0 && rec_o == '0));
    // R7: no wakeup flag rise outside standby
    a_r7_standby_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_i && !flags_o[F_WAKE]) |=> !flags_o[F_WAKE]);

endmodule

// File: tb/canerr_irq_top_test.sv
`timescale 1ns/1ps
module canerr_irq_top_test;

    localparam int NMB = 4;
    localparam int B_RH = 0, B_DAT = 1, B_RMT = 2, B_TXW = 3, B_RXW = 4, B_PAS = 5,
                   B_BO = 6, B_OVL = 7, B_EMP = 8, B_OVR = 9, B_WAK = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tec_inc, tec_dec, rec_inc, rec_dec, recseq, standby, rx_pin;
    logic [3:0] tec_amt, rec_amt;
    logic [NMB-1:0] rx_done, rmt_done, rx_pend, rmt_pend, tx_pend, mb_mask;
    logic ovld_sent, rsthlt_done;
    logic [10:0] src_mask, flag_clr;
    logic [10:0] flags;
    logic irq, bus_off;
    logic [8:0] tec;
    logic [7:0] rec;

    int checks = 0;
    int errors = 0;
    int tec_m = 0;
    int rec_m = 0;
    logic [10:0] exp_f = '0;

    always #4 clk = ~clk;

    canerr_irq_top uut (
        .clk(clk), .rst_n(rst_n),
        .tec_inc_i(tec_inc), .tec_dec_i(tec_dec), .tec_amt_i(tec_amt),
        .rec_inc_i(rec_inc), .rec_dec_i(rec_dec), .rec_amt_i(rec_amt),
        .recseq_i(recseq), .standby_i(standby), .rx_pin_i(rx_pin),
        .rx_done_i(rx_done), .rmt_done_i(rmt_done), .rx_pend_i(rx_pend),
        .rmt_pend_i(rmt_pend), .tx_pend_i(tx_pend), .mb_mask_i(mb_mask),
        .ovld_sent_i(ovld_sent), .rsthlt_done_i(rsthlt_done),
        .src_mask_i(src_mask), .flag_clr_i(flag_clr),
        .flags_o(flags), .irq_o(irq), .tec_o(tec), .rec_o(rec), .bus_off_o(bus_off)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        tec_inc = 0; tec_dec = 0; rec_inc = 0; rec_dec = 0; recseq = 0;
        tec_amt = 0; rec_amt = 0; rx_done = '0; rmt_done = '0;
        ovld_sent = 0; rsthlt_done = 0; flag_clr = '0;
    endtask

    task automatic clear_all();
        flag_clr = '1;
        tick();
        flag_clr = '0;
        exp_f = '0;
        check(flags == 11'h0, "R12 clear all", flags, 0);
    endtask

    task automatic cnt_op(input bit use_rec, input bit inc, input int amt,
                          input bit dec, input string tag);
        int oldv, newv, lim;
        oldv = use_rec ? rec_m : tec_m;
        lim  = use_rec ? 255 : 256;
        if (inc)                newv = (oldv + amt > lim) ? lim : oldv + amt;
        else if (dec && oldv > 0) newv = oldv - 1;
        else                    newv = oldv;
        if (use_rec) begin rec_inc = inc; rec_dec = dec; rec_amt = 4'(amt); end
        else         begin tec_inc = inc; tec_dec = dec; tec_amt = 4'(amt); end
        tick();
        idle();
        if (newv == 96 && oldv != 96) exp_f[use_rec ? B_RXW : B_TXW] = 1'b1;
        if (newv == 128 && oldv != 128) exp_f[B_PAS] = 1'b1;
        if (!use_rec && newv == 256 && oldv != 256) exp_f[B_BO] = 1'b1;
        if (use_rec) rec_m = newv; else tec_m = newv;
        check(tec == 9'(tec_m) && rec == 8'(rec_m), {tag, " counters"},
              {tec, 8'h0, rec}, {9'(tec_m), 8'h0, 8'(rec_m)});
        check(flags == exp_f, {tag, " flags"}, flags, exp_f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        standby = 0; rx_pin = 1; rx_pend = '0; rmt_pend = '0; tx_pend = '0;
        mb_mask = '1; src_mask = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(flags == 0 && irq == 0 && bus_off == 0, "R1 outputs", {flags, irq, bus_off}, 0);
        check(tec == 0 && rec == 0, "R1 counters", {tec, rec}, 0);

        // R2 R3 R4 transmit counter sweep up to 255 and down to 0
        for (int i = 0; i < 255; i++) cnt_op(0, 1, 1, 0, "R3 R4 tec up");
        clear_all();
        for (int i = 0; i < 256; i++) cnt_op(0, 0, 0, 1, "R3 R4 tec down");
        clear_all();
        // R2 R3 R4 receive counter sweep with saturation
        for (int i = 0; i < 260; i++) cnt_op(1, 1, 1, 0, "R2 R3 R4 rec up");
        clear_all();
        for (int i = 0; i < 256; i++) cnt_op(1, 0, 0, 1, "R3 R4 rec down");
        clear_all();
        // R2 R4 large steps on receive, saturation at 255
        for (int i = 0; i < 20; i++) cnt_op(1, 1, 15, 0, "R2 rec step15");
        for (int i = 0; i < 20; i++) cnt_op(1, 0, 0, 1, "R2 rec dec");
        clear_all();
        // R3 warning by steps of 8, then R2 increment priority
        for (int i = 0; i < 12; i++) cnt_op(0, 1, 8, 0, "R3 tec step8");
        cnt_op(0, 1, 3, 1, "R2 inc wins");
        // R5 bus-off entry
        while (tec_m < 256) cnt_op(0, 1, 8, 0, "R5 tec to full");
        check(bus_off == 1, "R5 bus_off high", bus_off, 1);
        tick();
        tec_m = 0; rec_m = 0;
        check(tec == 0 && rec == 0, "R5 counters cleared", {tec, rec}, 0);
        tec_inc = 1; tec_amt = 4'd5; rec_inc = 1; rec_amt = 4'd7;
        tick();
        idle();
        check(tec == 0 && rec == 0 && flags == exp_f, "R5 strobes ignored",
              {tec, rec, flags}, {17'h0, exp_f});
        clear_all();
        // R6 recovery after 128 runs
        for (int i = 0; i < 127; i++) begin recseq = 1; tick(); end
        recseq = 0;
        check(bus_off == 1 && flags == 0, "R6 still bus-off after 127", {bus_off, flags}, {1'b1, 11'h0});
        recseq = 1; tick(); recseq = 0;
        exp_f[B_BO] = 1'b1;
        check(bus_off == 0, "R6 bus_off low", bus_off, 0);
        check(flags == exp_f, "R6 flag on leave", flags, exp_f);
        clear_all();
        for (int i = 0; i < 130; i++) begin recseq = 1; tick(); end
        recseq = 0;
        check(bus_off == 0 && flags == 0, "R6 runs outside bus-off", {bus_off, flags}, 0);

        // R7 wakeup
        standby = 0; rx_pin = 0; tick(); rx_pin = 1; tick();
        check(flags == 0, "R7 no wake outside standby", flags, 0);
        standby = 1; rx_pin = 0; tick();
        check(flags == 11'(1 << B_WAK), "R7 wake in standby", flags, 1 << B_WAK);
        rx_pin = 1; standby = 0; tick();
        clear_all();

        // R8 R9 mailbox sweep
        for (int mb = 0; mb < NMB; mb++)
            for (int msk = 0; msk < 2; msk++)
                for (int pend = 0; pend < 4; pend++)
                    for (int kind = 0; kind < 2; kind++) begin
                        logic [10:0] e;
                        mb_mask = '1; mb_mask[mb] = msk[0];
                        rx_pend = '0; rx_pend[mb] = pend[0];
                        rmt_pend = '0; rmt_pend[mb] = pend[1];
                        if (kind == 0) rx_done[mb] = 1'b1; else rmt_done[mb] = 1'b1;
                        tick();
                        idle();
                        e = '0;
                        if (msk == 0) begin
                            e[kind == 0 ? B_DAT : B_RMT] = 1'b1;
                            if (pend != 0) e[B_OVR] = 1'b1;
                        end
                        check(flags == e, "R8 R9 mailbox case", flags, e);
                        clear_all();
                    end
        rx_pend = '0; rmt_pend = '0; mb_mask = '1;

        // R10 mailbox empty
        tx_pend = 4'b0100; tick();
        check(flags == 0, "R10 rise sets nothing", flags, 0);
        tx_pend = 4'b0110; tick();
        tx_pend = 4'b0010; tick();
        check(flags == 11'(1 << B_EMP), "R10 fall sets empty", flags, 1 << B_EMP);
        clear_all();
        tx_pend = 4'b0000; tick();
        check(flags == 11'(1 << B_EMP), "R10 second fall", flags, 1 << B_EMP);
        clear_all();

        // R11 overload and reset/halt
        ovld_sent = 1; tick(); idle();
        check(flags == 11'(1 << B_OVL), "R11 overload", flags, 1 << B_OVL);
        rsthlt_done = 1; tick(); idle();
        check(flags == 11'((1 << B_OVL) | (1 << B_RH)), "R11 reset/halt", flags,
              (1 << B_OVL) | (1 << B_RH));

        // R12 partial clear and set priority
        flag_clr = 11'(1 << B_RH); tick(); idle();
        check(flags == 11'(1 << B_OVL), "R12 partial clear", flags, 1 << B_OVL);
        flag_clr = '1; ovld_sent = 1; tick(); idle();
        check(flags == 11'(1 << B_OVL), "R12 set beats clear", flags, 1 << B_OVL);

        // R13 interrupt under every mask, with and without the reset/halt flag
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin rsthlt_done = 1; standby = 1; rx_pin = 0; tick(); idle();
                                 rx_pin = 1; standby = 0; tick(); end
            for (int m = 0; m < 2048; m++) begin
                logic [10:0] fm;
                logic ex;
                src_mask = 11'(m);
                #1;
                fm = flags & ~{src_mask[10:1], 1'b0};
                ex = |fm;
                check(irq == ex, "R13 irq vs mask", irq, ex);
            end
            src_mask = '0;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule